// File: doc/BRIEF.md
# Slot Arbiter with Manager Interleave

This block decides which execution thread receives the next instruction slot. One manager thread and `NUM_CH` channel threads raise request lines. Whenever the slot strobe is high, the arbiter registers a one-hot grant that appears on the following cycle and lasts for that cycle only.

Channels share the slots in a rotating order, and every channel has the same priority. After each channel grant, the manager is offered the next slot before any other channel is served. However many channels are busy, the manager is never locked out for longer than one channel grant. There are no configuration inputs; the order is fixed by the hardware.

If the manager does not request on its turn, the slot goes straight to the next requesting channel. A slot with no requests at all produces no grant and leaves the internal state untouched.

Top module: `slot_arbiter`

## Requirements
- R1: Reset forces the grant to zero, sets the rotation to start at channel 0, and gives the manager preference for the first slot.
- R2: The grant is `NUM_CH+1` bits wide. Bit 0 is the manager and bit k+1 is channel k. At most one bit is ever high.
- R3: A grant appears only in the cycle after a cycle with the slot strobe high. The cycle after a slot-low cycle shows an all-zero grant.
- R4: A grant bit is only ever set for a requester whose request line was high in the slot cycle.
- R5: When the previous grant went to a channel and the manager requests at the next slot, the manager receives that slot.
- R6: When it is the manager's turn but the manager is not requesting, the slot goes to the next requesting channel in the rotation.
- R7: The channel search starts at the channel after the last granted channel, skips channels that are not requesting, and wraps from the highest channel to channel 0.
- R8: A slot with no requests gives an all-zero grant and leaves the rotation position and the manager turn unchanged.
- R9: A slot with at least one request always produces a grant.
- R10: When the manager is the only requester, it is granted even if its turn has already been used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| slot_i | input | 1 | An instruction slot is available this cycle |
| mgr_req_i | input | 1 | Manager thread requests a slot |
| ch_req_i | input | NUM_CH | Request line for each channel thread |
| grant_o | output | NUM_CH+1 | Registered one-hot grant: bit 0 is the manager, bit k+1 is channel k |

## Verification
The hardest states to reach from the ports are those with a hidden manager turn flag and a rotation pointer that sit in an unusual combination. Two examples are a pointer that must wrap past non-requesting channels while the manager is idle on its turn, and a slot with no requests that must leave both the flag and the pointer untouched. The stimulus walks a fixed sequence of slots that steers the pointer through a skip, a wrap and an empty slot. Each later grant exposes the state that the earlier slots left behind. A mid-run reset followed by a full request pattern then shows that the rotation position returns to channel 0.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Source chosen for a slot.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MGR  = 2'd1,
        SRC_CH   = 2'd2
    } grant_src_e;

    // Index width for a channel count (at least one bit).
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned IDX_W  = 2
) (
    input  logic [NUM_CH-1:0] req_i,
    input  logic [IDX_W-1:0]  start_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o
);

    // Walk offsets from the highest down so the smallest offset wins.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int off = NUM_CH - 1; off >= 0; off--) begin
            int cand;
            cand = int'(start_i) + off;
            if (cand >= int'(NUM_CH)) begin
                cand = cand - int'(NUM_CH);
            end
            if (req_i[cand]) begin
                hit_o = 1'b1;
                idx_o = cand[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/arb_decide.sv
module arb_decide
    import arb_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned IDX_W  = 2
) (
    input  logic              mgr_req_i,
    input  logic [NUM_CH-1:0] ch_req_i,
    input  logic              mgr_turn_i,
    input  logic [IDX_W-1:0]  ptr_i,
    output grant_src_e        src_o,
    output logic [IDX_W-1:0]  ch_idx_o
);

    logic ch_hit;

    arb_rr_pick #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_pick (
        .req_i   (ch_req_i),
        .start_i (ptr_i),
        .hit_o   (ch_hit),
        .idx_o   (ch_idx_o)
    );

    // Manager wins on its turn, or whenever no channel is asking.
    always_comb begin
        if (mgr_req_i && (mgr_turn_i || !ch_hit)) begin
            src_o = SRC_MGR;
        end else if (ch_hit) begin
            src_o = SRC_CH;
        end else begin
            src_o = SRC_NONE;
        end
    end

endmodule

// File: rtl/arb_turn_state.sv
module arb_turn_state
    import arb_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned IDX_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_i,
    input  grant_src_e       src_i,
    input  logic [IDX_W-1:0] ch_idx_i,
    output logic             mgr_turn_o,
    output logic [IDX_W-1:0] ptr_o
);

    localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(NUM_CH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            mgr_turn_o <= 1'b1;
            ptr_o      <= '0;
        end else if (take_i) begin
            unique case (src_i)
                SRC_MGR: mgr_turn_o <= 1'b0;
                SRC_CH: begin
                    mgr_turn_o <= 1'b1;
                    ptr_o      <= (ch_idx_i == LAST_CH) ? '0 : ch_idx_i + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_i,
    input  logic              mgr_req_i,
    input  logic [NUM_CH-1:0] ch_req_i,
    output logic [NUM_CH:0]   grant_o
);

    localparam int unsigned IDX_W = idx_bits(NUM_CH);

    grant_src_e       src;
    logic [IDX_W-1:0] ch_idx;
    logic             mgr_turn;
    logic [IDX_W-1:0] ptr;
    logic [NUM_CH:0]  grant_d;

    arb_decide #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_decide (
        .mgr_req_i  (mgr_req_i),
        .ch_req_i   (ch_req_i),
        .mgr_turn_i (mgr_turn),
        .ptr_i      (ptr),
        .src_o      (src),
        .ch_idx_o   (ch_idx)
    );

    arb_turn_state #(
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_state (
        .clk        (clk),
        .rst        (rst),
        .take_i     (slot_i),
        .src_i      (src),
        .ch_idx_i   (ch_idx),
        .mgr_turn_o (mgr_turn),
        .ptr_o      (ptr)
    );

    // One-hot encode of the decision, gated by the slot strobe.
    assign grant_d[0] = slot_i && (src == SRC_MGR);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch_grant
        assign grant_d[k+1] = slot_i && (src == SRC_CH) && (ch_idx == IDX_W'(k));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_o <= '0;
        end else begin
            grant_o <= grant_d;
        end
    end

endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
    parameter int unsigned NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              slot_i,
    input logic              mgr_req_i,
    input logic [NUM_CH-1:0] ch_req_i,
    input logic [NUM_CH:0]   grant_o
);

    // Tracks whether the most recent visible grant went to a channel.
    logic last_ch_q;
    logic last_ch_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_ch_q <= 1'b0;
        end else if (|grant_o[NUM_CH:1]) begin
            last_ch_q <= 1'b1;
        end else if (grant_o[0]) begin
            last_ch_q <= 1'b0;
        end
    end

    assign last_ch_eff = (|grant_o[NUM_CH:1]) ? 1'b1 :
                         (grant_o[0] ? 1'b0 : last_ch_q);

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    // R3
    idle_slot_chk: assert property (@(posedge clk) disable iff (rst)
        !slot_i |=> (grant_o == '0));

    // R4
    mgr_requested_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_i && !mgr_req_i) |=> !grant_o[0]);

    // R4
    ch_requested_chk: assert property (@(posedge clk) disable iff (rst)
        slot_i |=> ((grant_o[NUM_CH:1] & ~$past(ch_req_i)) == '0));

    // R9
    work_conserving_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_i && (mgr_req_i || (|ch_req_i))) |=> (grant_o != '0));

    // R5
    mgr_interleave_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_i && mgr_req_i && last_ch_eff) |=> grant_o[0]);

    // R10
    mgr_alone_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_i && mgr_req_i && (ch_req_i == '0)) |=> grant_o[0]);

endmodule

bind slot_arbiter arb_chk #(
    .NUM_CH (NUM_CH)
) u_arb_chk (
    .clk       (clk),
    .rst       (rst),
    .slot_i    (slot_i),
    .mgr_req_i (mgr_req_i),
    .ch_req_i  (ch_req_i),
    .grant_o   (grant_o)
);

// File: tb/test_slot_arbiter.sv
module test_slot_arbiter;

    localparam int unsigned NUM_CH = 4;
    localparam int unsigned NVEC   = 14;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              slot_i = 1'b0;
    logic              mgr_req_i = 1'b0;
    logic [NUM_CH-1:0] ch_req_i = '0;
    logic [NUM_CH:0]   grant_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    slot_arbiter #(.NUM_CH(NUM_CH)) i_slot_arbiter (
        .clk       (clk),
        .rst       (rst),
        .slot_i    (slot_i),
        .mgr_req_i (mgr_req_i),
        .ch_req_i  (ch_req_i),
        .grant_o   (grant_o)
    );

    // Vector layout: [10] manager request, [9:6] channel requests,
    // [5] slot strobe, [4:0] expected grant one cycle later.
    localparam logic [10:0] VEC [NVEC] = '{
        11'b1_1111_1_00001,  // R1: manager preferred first
        11'b1_1111_1_00010,  // R7: channel 0
        11'b1_1111_1_00001,  // R5: manager after channel
        11'b1_1111_1_00100,  // R7: channel 1
        11'b0_1111_1_01000,  // R6: idle manager, channel 2
        11'b0_0001_1_00010,  // R7: skip 3, wrap to 0
        11'b1_1111_0_00000,  // R3: no slot
        11'b0_0000_1_00000,  // R8: no requests
        11'b0_1001_1_10000,  // R8: pointer kept at 1, picks 3
        11'b1_0000_1_00001,  // R9: manager on turn
        11'b1_0000_1_00001,  // R10: manager alone off turn
        11'b1_0100_1_01000,  // R7: channel 2 off manager turn
        11'b1_0100_1_00001,  // R5: manager again
        11'b0_0100_1_01000   // R7: wrap back to channel 2
    };

    string VTAG [NVEC] = '{"R1", "R7", "R5", "R7", "R6", "R7", "R3",
                           "R8", "R8", "R9", "R10", "R7", "R5", "R7"};

    task automatic check(input string tag, input logic [NUM_CH:0] exp);
        checks++;
        if (grant_o !== exp) begin
            errors++;
            $display("FAIL %s: grant actual %b expected %b", tag, grant_o, exp);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge.
    task automatic step(input logic m, input logic [NUM_CH-1:0] c,
                        input logic s, input logic [NUM_CH:0] exp,
                        input string tag);
        mgr_req_i = m;
        ch_req_i  = c;
        slot_i    = s;
        @(negedge clk);
        check(tag, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", '0);  // during reset
        rst = 1'b0;
        @(negedge clk);
        check("R1", '0);  // just after reset

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][10], VEC[i][9:6], VEC[i][5], VEC[i][4:0], VTAG[i]);
            checks++;
            if ($countones(grant_o) > 1) begin
                errors++;
                $display("FAIL R2: grant actual %b expected at most one bit", grant_o);
            end
        end

        // Mid-run reset: the rotation returns to channel 0.
        slot_i = 1'b0;
        rst    = 1'b1;
        @(negedge clk);
        check("R1", '0);
        rst = 1'b0;
        step(1'b0, 4'b1111, 1'b1, 5'b00010, "R1");
        step(1'b1, 4'b1111, 1'b1, 5'b00001, "R5");
        step(1'b1, 4'b1111, 1'b0, 5'b00000, "R3");
        step(1'b0, 4'b0010, 1'b1, 5'b00100, "R4");
        step(1'b0, 4'b0000, 1'b0, 5'b00000, "R3");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule